// File: doc/BRIEF.md
# Zone Password Security Lock

This block keeps the security state of one memory zone. A 128-bit password arrives from nonvolatile storage after reset and is held in the block. Software writes a 128-bit key as four 32-bit words. A dummy read of the password location arms the block. Once the block is armed and all four key words have been written since that arm, a key equal to the password unsecures the zone. The block drives a zone-secure flag, which gates debug and reprogramming access elsewhere. It also drives an execute-only enable.

Two password values override the compare. A password of all zeros keeps the zone secure for good. A password of all ones leaves the zone open. A separate one-time lock code also decides whether the zone is protected at all. The code 0x1111 means the zone is never secured, and every other code protects it.

Top module: `zone_pw_lock`

## Requirements
- R1: While reset is asserted, and after it is released, `zone_secure` is 1, `exec_only_en` is 1 and `armed` is 0. Reset also clears the key words and the stored password, and a new load is needed before the block can be armed.
- R2: A cycle with `pw_ld_valid` high captures `pw_ld_data` as the password at that clock edge. A load also clears `armed`, and it has priority over an arm request in the same cycle.
- R3: A `pw_rd` pulse sets `armed` at the next edge, but only if a password has been loaded since reset. A `pw_rd` pulse before any load is ignored.
- R4: A `key_wr` cycle stores `key_data` into key word `key_idx`. Word n covers key bits [32n+31:32n], the same bit slice as the password. Each write changes that word only.
- R5: A key compare counts only when all four word indices have been written since the last arm. Every arm forgets earlier writes, even when the key values they left are still correct.
- R6: With the lock code not 0x1111 and a password that is neither all zeros nor all ones, `zone_secure` and `exec_only_en` go to 0 in the cycle after the write that completes a matching, fully written key on an armed block.
- R7: A key word that differs from the password keeps, or returns, `zone_secure` and `exec_only_en` at 1.
- R8: An all-zero password keeps `zone_secure` at 1 whatever key is written. `exec_only_en` then stays 1.
- R9: An all-ones password makes `zone_secure` 0 (lock code not 0x1111). It makes `exec_only_en` 0 once the block is armed, and leaves it at 1 while the block is unarmed.
- R10: A lock code of 0x1111 forces `zone_secure` to 0 in the same cycle, and does not change `exec_only_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pw_ld_valid | input | 1 | Password load strobe from nonvolatile storage |
| pw_ld_data | input | 128 | Password value to load |
| pw_rd | input | 1 | Dummy read of the password location (arm request) |
| key_wr | input | 1 | Key word write strobe |
| key_idx | input | 2 | Key word index |
| key_data | input | 32 | Key word value |
| lock_code | input | 16 | One-time lock field; 0x1111 leaves the zone open |
| zone_secure | output | 1 | Zone is secured |
| exec_only_en | output | 1 | Execute-only protection enable |
| armed | output | 1 | Block armed by a password read |

## Verification
Some properties are checked on every cycle:
- the unlocking lock code always opens the zone;
- a zero password always secures the zone;
- an unarmed block always keeps the execute-only enable;
- an open zone with an ordinary password implies an armed block with all four words written;
- arming and load behave as specified;
- an arm clears the record of written words.

Other behaviour can only be shown by the bench's scenarios:
- the exact cycle an unlock appears;
- word indexing, shown by a wrong word followed by a repair;
- the effect of re-arming on a key that is already correct;
- ignored arm requests before a load;
- the all-ones case;
- a reset in the middle of a run.

// File: rtl/zlock_pkg.sv
package zlock_pkg;
  typedef struct packed {
    logic armed;
    logic pw_zero;
    logic pw_ones;
    logic key_eq;
  } zlock_stat_t;
endpackage

// File: rtl/zlock_rst_sync.sv
module zlock_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/zlock_pw_store.sv
module zlock_pw_store #(
  parameter int unsigned KEY_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_i,
  input  logic [KEY_W-1:0] ld_data_i,
  input  logic             rd_i,
  output logic [KEY_W-1:0] pw_o,
  output logic             armed_o,
  output logic             arm_o
);
  logic [KEY_W-1:0] pw_q, pw_d;
  logic             loaded_q, loaded_d;
  logic             armed_q, armed_d;

  // an arm request counts only after a load and loses to a load in the same cycle
  assign arm_o = rd_i & loaded_q & ~ld_i;

  always_comb begin
    pw_d     = pw_q;
    loaded_d = loaded_q;
    armed_d  = armed_q;
    if (ld_i) begin
      pw_d     = ld_data_i;
      loaded_d = 1'b1;
      armed_d  = 1'b0;
    end else if (arm_o) begin
      armed_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_q     <= '0;
      loaded_q <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      pw_q     <= pw_d;
      loaded_q <= loaded_d;
      armed_q  <= armed_d;
    end
  end

  assign pw_o    = pw_q;
  assign armed_o = armed_q;

  // R3: arming only follows a read issued after a load
  p_arm_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(rd_i && loaded_q));

  // R2: a load always leaves the block unarmed
  p_load_disarms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> !armed_q);
endmodule

// File: rtl/zlock_key_bank.sv
module zlock_key_bank #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned N_WORDS = 4,
  localparam int unsigned IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
  localparam int unsigned KEY_W  = WORD_W * N_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              clr_i,
  output logic [KEY_W-1:0]  key_o,
  output logic              all_seen_o
);
  logic [N_WORDS-1:0][WORD_W-1:0] word_q, word_d;
  logic [N_WORDS-1:0]             seen_q, seen_d;

  always_comb begin
    word_d = word_q;
    seen_d = clr_i ? '0 : seen_q;
    for (int i = 0; i < N_WORDS; i++) begin
      if (wr_i && (idx_i == IDX_W'(i))) begin
        word_d[i] = data_i;
        seen_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      seen_q <= '0;
    end else begin
      word_q <= word_d;
      seen_q <= seen_d;
    end
  end

  for (genvar g = 0; g < N_WORDS; g++) begin : g_flat
    assign key_o[g*WORD_W +: WORD_W] = word_q[g];
  end

  assign all_seen_o = &seen_q;

  // R5: an arm without a write in the same cycle forgets every prior write
  p_arm_clears_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !wr_i) |=> (seen_q == '0));

  // R4: a write marks its own index as written
  p_write_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> seen_q[$past(idx_i)]);
endmodule

// File: rtl/zlock_decide.sv
module zlock_decide
  import zlock_pkg::*;
#(
  parameter int unsigned KEY_W       = 128,
  parameter int unsigned LOCK_W      = 16,
  parameter int unsigned UNLOCK_CODE = 'h1111
) (
  input  logic [KEY_W-1:0]  pw_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              all_seen_i,
  input  logic              armed_i,
  input  logic [LOCK_W-1:0] lock_i,
  output zlock_stat_t       stat_o,
  output logic              secure_o,
  output logic              exec_en_o
);
  logic lock_open;
  logic release_ok;

  always_comb begin
    stat_o.armed   = armed_i;
    stat_o.pw_zero = (pw_i == '0);
    stat_o.pw_ones = (pw_i == '1);
    stat_o.key_eq  = armed_i & all_seen_i & (key_i == pw_i);
    lock_open      = (lock_i == LOCK_W'(UNLOCK_CODE));
    release_ok     = ~stat_o.pw_zero & (stat_o.pw_ones | stat_o.key_eq);
    secure_o       = ~lock_open & ~release_ok;
    exec_en_o      = ~(stat_o.armed & release_ok);
  end
endmodule

// File: rtl/zone_pw_lock.sv
module zone_pw_lock
  import zlock_pkg::*;
#(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned N_WORDS     = 4,
  parameter int unsigned LOCK_W      = 16,
  parameter int unsigned UNLOCK_CODE = 'h1111,
  localparam int unsigned KEY_W      = WORD_W * N_WORDS,
  localparam int unsigned IDX_W      = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pw_ld_valid,
  input  logic [KEY_W-1:0]  pw_ld_data,
  input  logic              pw_rd,
  input  logic              key_wr,
  input  logic [IDX_W-1:0]  key_idx,
  input  logic [WORD_W-1:0] key_data,
  input  logic [LOCK_W-1:0] lock_code,
  output logic              zone_secure,
  output logic              exec_only_en,
  output logic              armed
);
  logic              rst_sync_n;
  logic [KEY_W-1:0]  pw;
  logic [KEY_W-1:0]  key;
  logic              arm_pulse;
  logic              all_seen;
  zlock_stat_t       stat;

  zlock_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  zlock_pw_store #(.KEY_W(KEY_W)) u_pw (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ld_i      (pw_ld_valid),
    .ld_data_i (pw_ld_data),
    .rd_i      (pw_rd),
    .pw_o      (pw),
    .armed_o   (armed),
    .arm_o     (arm_pulse)
  );

  zlock_key_bank #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_key (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_i       (key_wr),
    .idx_i      (key_idx),
    .data_i     (key_data),
    .clr_i      (arm_pulse),
    .key_o      (key),
    .all_seen_o (all_seen)
  );

  zlock_decide #(.KEY_W(KEY_W), .LOCK_W(LOCK_W), .UNLOCK_CODE(UNLOCK_CODE)) u_dec (
    .pw_i       (pw),
    .key_i      (key),
    .all_seen_i (all_seen),
    .armed_i    (armed),
    .lock_i     (lock_code),
    .stat_o     (stat),
    .secure_o   (zone_secure),
    .exec_en_o  (exec_only_en)
  );

  // R10: the unlocking code always leaves the zone open
  p_unlock_code_open_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lock_code == LOCK_W'(UNLOCK_CODE)) |-> !zone_secure);

  // R8: a zero password in storage keeps a protected zone secure
  p_zero_pw_secure_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((pw == '0) && (lock_code != LOCK_W'(UNLOCK_CODE))) |-> zone_secure);

  // R9: execute-only protection stays on while unarmed
  p_unarmed_exec_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !armed |-> exec_only_en);

  // R6: an ordinary password opens a protected zone only after a complete key on an armed block
  p_open_needs_full_key_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!zone_secure && (lock_code != LOCK_W'(UNLOCK_CODE)) && (pw != '1)) |-> (armed && all_seen && stat.key_eq));
endmodule

// File: tb/sim_zone_pw_lock.sv
module sim_zone_pw_lock;
  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [15:0] LK_PROT = 16'hA5A5;
  localparam logic [15:0] LK_OPEN = 16'h1111;
  localparam logic [127:0] PW_A = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pw_ld_valid;
  logic [127:0] pw_ld_data;
  logic         pw_rd;
  logic         key_wr;
  logic [1:0]   key_idx;
  logic [31:0]  key_data;
  logic [15:0]  lock_code;
  logic         zone_secure, exec_only_en, armed;

  typedef struct {
    logic  sec;
    logic  ex;
    logic  arm;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zone_pw_lock u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .pw_ld_valid  (pw_ld_valid),
    .pw_ld_data   (pw_ld_data),
    .pw_rd        (pw_rd),
    .key_wr       (key_wr),
    .key_idx      (key_idx),
    .key_data     (key_data),
    .lock_code    (lock_code),
    .zone_secure  (zone_secure),
    .exec_only_en (exec_only_en),
    .armed        (armed)
  );

  // monitor: compares the oldest expected item at each falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if ({zone_secure, exec_only_en, armed} !== {e.sec, e.ex, e.arm}) begin
          n_bad++;
          $display("FAIL %s: secure/exec/armed actual %b%b%b expected %b%b%b",
                   e.req, zone_secure, exec_only_en, armed, e.sec, e.ex, e.arm);
        end
      end
    end
  end

  // driver: one operation per cycle, then push what the requirements predict
  task automatic op(input logic ld, input logic [127:0] ld_d, input logic rd,
                    input logic wr, input logic [1:0] idx, input logic [31:0] d,
                    input logic [15:0] lk, input logic es, input logic ee,
                    input logic ea, input string req);
    exp_t e;
    @(negedge clk); #1;
    pw_ld_valid = ld; pw_ld_data = ld_d; pw_rd = rd;
    key_wr = wr; key_idx = idx; key_data = d; lock_code = lk;
    @(posedge clk); #1;
    pw_ld_valid = 1'b0; pw_rd = 1'b0; key_wr = 1'b0;
    e.sec = es; e.ex = ee; e.arm = ea; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic idle(input logic [15:0] lk, input logic es, input logic ee,
                      input logic ea, input string req);
    op(1'b0, '0, 1'b0, 1'b0, 2'd0, '0, lk, es, ee, ea, req);
  endtask

  task automatic wkey(input logic [1:0] i, input logic [31:0] d,
                      input logic es, input logic ee, input string req);
    op(1'b0, '0, 1'b0, 1'b1, i, d, LK_PROT, es, ee, 1'b1, req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pw_ld_valid = 1'b0; pw_ld_data = '0; pw_rd = 1'b0;
    key_wr = 1'b0; key_idx = '0; key_data = '0; lock_code = LK_PROT;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    idle(LK_PROT, 1, 1, 0, "R1 reset state");
    // R3: arm request before any load is ignored
    op(0, '0, 1, 0, 0, '0, LK_PROT, 1, 1, 0, "R3 arm before load");
    // R2: load captures password, block stays unarmed
    op(1, PW_A, 0, 0, 0, '0, LK_PROT, 1, 1, 0, "R2 load");
    op(0, '0, 1, 0, 0, '0, LK_PROT, 1, 1, 1, "R3 arm after load");
    // R4, R6: unlock on the write that completes the key
    wkey(0, PW_A[31:0],   1, 1, "R4 word0");
    wkey(1, PW_A[63:32],  1, 1, "R4 word1");
    wkey(2, PW_A[95:64],  1, 1, "R4 word2");
    wkey(3, PW_A[127:96], 0, 0, "R6 key complete");
    // R5: re-arm forgets writes even though key values are still right
    op(0, '0, 1, 0, 0, '0, LK_PROT, 1, 1, 1, "R5 rearm clears");
    wkey(2, PW_A[95:64],  1, 1, "R5 partial");
    wkey(0, PW_A[31:0],   1, 1, "R5 partial");
    wkey(3, PW_A[127:96], 1, 1, "R5 partial");
    wkey(1, PW_A[63:32],  0, 0, "R5 full after rearm");
    // R7: wrong word relocks, repairing that word reopens
    wkey(1, ~PW_A[63:32], 1, 1, "R7 wrong word");
    wkey(1, PW_A[63:32],  0, 0, "R4 word1 repaired");
    wkey(2, 32'h0,        1, 1, "R7 wrong word2");
    // R10: unlocking code opens the zone, execute-only unchanged
    idle(LK_OPEN, 0, 1, 1, "R10 open code");
    idle(LK_PROT, 1, 1, 1, "R10 protect code back");
    // R8: zero password
    op(1, '0, 0, 0, 0, '0, LK_PROT, 1, 1, 0, "R2 load disarms");
    op(0, '0, 1, 0, 0, '0, LK_PROT, 1, 1, 1, "R8 arm");
    for (int i = 0; i < 4; i++) wkey(2'(i), 32'h0, 1, 1, "R8 zero pw secure");
    // R9: all-ones password
    op(1, '1, 0, 0, 0, '0, LK_PROT, 0, 1, 0, "R9 ones unarmed");
    // R2: load beats arm in the same cycle
    op(1, '1, 1, 0, 0, '0, LK_PROT, 0, 1, 0, "R2 load over arm");
    op(0, '0, 1, 0, 0, '0, LK_PROT, 0, 0, 1, "R9 ones armed");
    // R1: asynchronous reset mid-run
    @(negedge clk); #2 rst_n = 1'b0;
    idle(LK_PROT, 1, 1, 0, "R1 reset asserted");
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    idle(LK_PROT, 1, 1, 0, "R1 after reset");
    op(0, '0, 1, 0, 0, '0, LK_PROT, 1, 1, 0, "R1 no arm without reload");

    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule